// File: doc/BRIEF.md
# Program Counter with Staged Jump High Byte

This block is the instruction address register of a small processor whose internal data bus is narrower than its address. A 16-bit address cannot arrive in one bus transfer, so a jump is built in two steps. The program first writes the upper byte of the target into a staging register. Later it issues a jump write. On that clock edge the low byte of the counter takes the bus value and the high byte takes the staged value, so the new address appears complete in one step. The staged byte stays in place until it is written again, so several jumps within the same 256-byte page need only one staging write.

Between jumps the phase sequencer asks the counter to advance once for every program memory read. That covers the opcode fetch and any literal operand read. The count carries from byte to byte and wraps from the top of the 64K space back to zero. A jump that the decoder has inhibited reaches this block as no write at all, so only a pending increment can move the counter. The address width is set by a byte-count parameter. With more than two bytes, successive staging writes shift in from the bottom of the staging register.

Top module: `jump_pc`

## Requirements
- R1: While rst_n is low, pc_addr is 0x0000 and the staging register is cleared. A jump taken after reset with no staging write yields high byte 0x00.
- R2: With pc_inc high and pc_wr low, pc_addr is one greater after the next rising clock edge.
- R3: An increment from a low byte of 0xFF clears the low byte and adds one to the high byte. For example, 0x00FF becomes 0x0100.
- R4: An increment from 0xFFFF gives 0x0000.
- R5: With pc_wr high, after the next edge pc_addr[7:0] equals the bus_in value of that cycle and pc_addr[15:8] equals the staged byte.
- R6: A staging write (hi_wr high, pc_wr and pc_inc low) leaves pc_addr unchanged.
- R7: The staged byte keeps its value through any number of jumps and increments until hi_wr is asserted again.
- R8: When pc_wr and pc_inc are both high, the write takes effect and the increment is dropped.
- R9: When hi_wr and pc_wr are high in the same cycle, the jump uses the staged byte from before that edge, and the new bus value becomes the staged byte for later jumps.
- R10: With pc_wr and pc_inc both low, pc_addr holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 8 | Internal data bus |
| hi_wr | input | 1 | Write strobe that loads bus_in into the staging register |
| pc_wr | input | 1 | Jump write: low byte from bus_in, high byte from the staging register |
| pc_inc | input | 1 | Increment request from the phase sequencer |
| pc_addr | output | 16 | Current program address |

## Verification
Every result is due exactly one rising edge after the cycle in which its strobes and bus value are presented. The counter and the staging register are the only storage, and nothing combinational runs from input to output. The bench applies each stimulus on a falling edge and advances its model at the following rising edge. It compares pc_addr at the next falling edge, so every comparison lands one cycle after its stimulus and clear of the edge. The staged byte cannot be seen at the ports, so it is checked one cycle late through the high byte of a subsequent jump.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int PCS_BUS_W      = 8;
    localparam int PCS_ADDR_BYTES = 2;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_STEP = 2'd1,
        PC_LOAD = 2'd2
    } pc_act_e;

endpackage

// File: rtl/pcs_hi_stage.sv
module pcs_hi_stage #(
    parameter int BUS_W = 8,
    parameter int HI_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] din,
    output logic [HI_W-1:0]  stage_q
);

    typedef struct packed {
        logic [HI_W-1:0] val;
    } stage_t;

    stage_t          st_d, st_q;
    logic [HI_W-1:0] shifted;

    generate
        if (HI_W > BUS_W) begin : g_shift
            assign shifted = {st_q.val[HI_W-BUS_W-1:0], din};
        end else begin : g_direct
            assign shifted = din;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.val = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_q = st_q.val;

endmodule

// File: rtl/pcs_byte_slice.sv
module pcs_byte_slice #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pcs_pkg::pc_act_e act,
    input  logic [W-1:0]     load_val,
    input  logic             carry_in,
    output logic [W-1:0]     q
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } slice_t;

    slice_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        unique case (act)
            pcs_pkg::PC_LOAD: sl_d.cnt = load_val;
            pcs_pkg::PC_STEP: sl_d.cnt = carry_in ? sl_q.cnt + 1'b1 : sl_q.cnt;
            default:          sl_d.cnt = sl_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign q = sl_q.cnt;

endmodule

// File: rtl/jump_pc.sv
module jump_pc #(
    parameter int BUS_W      = pcs_pkg::PCS_BUS_W,
    parameter int ADDR_BYTES = pcs_pkg::PCS_ADDR_BYTES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BUS_W-1:0]            bus_in,
    input  logic                        hi_wr,
    input  logic                        pc_wr,
    input  logic                        pc_inc,
    output logic [BUS_W*ADDR_BYTES-1:0] pc_addr
);

    localparam int ADDR_W = BUS_W * ADDR_BYTES;
    localparam int HI_W   = ADDR_W - BUS_W;

    typedef struct packed {
        pcs_pkg::pc_act_e act;
    } ctl_t;

    ctl_t            ctl_d;
    logic [HI_W-1:0] stage_q;

    // Write has priority over increment; no strobe means hold.
    always_comb begin
        ctl_d.act = pcs_pkg::PC_HOLD;
        if (pc_wr) begin
            ctl_d.act = pcs_pkg::PC_LOAD;
        end else if (pc_inc) begin
            ctl_d.act = pcs_pkg::PC_STEP;
        end
    end

    pcs_hi_stage #(
        .BUS_W (BUS_W),
        .HI_W  (HI_W)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hi_wr),
        .din     (bus_in),
        .stage_q (stage_q)
    );

    generate
        for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
            logic [BUS_W-1:0] ld;
            logic             cin;
            if (b == 0) begin : g_low
                assign ld  = bus_in;
                assign cin = 1'b1;
            end else begin : g_up
                assign ld  = stage_q[(b-1)*BUS_W +: BUS_W];
                assign cin = &pc_addr[b*BUS_W-1:0];
            end
            pcs_byte_slice #(
                .W (BUS_W)
            ) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .act      (ctl_d.act),
                .load_val (ld),
                .carry_in (cin),
                .q        (pc_addr[b*BUS_W +: BUS_W])
            );
        end
    endgenerate

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 16,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_W-1:0]  bus_in,
    input logic              hi_wr,
    input logic              pc_wr,
    input logic              pc_inc,
    input logic [ADDR_W-1:0] pc_addr,
    input logic [HI_W-1:0]   stage_q
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (pc_addr == '0); // R1
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !pc_wr && !pc_inc) |=> $stable(pc_addr)); // R10

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !pc_wr && pc_inc) |=> (pc_addr == ADDR_W'($past(pc_addr) + 1'b1))); // R2

    AST_JUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pc_wr) |=> (pc_addr[BUS_W-1:0] == $past(bus_in))); // R8

    AST_JUMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pc_wr) |=> (pc_addr[ADDR_W-1:BUS_W] == $past(stage_q))); // R5

    AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !hi_wr) |=> $stable(stage_q)); // R7

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hi_wr && !pc_wr && !pc_inc) |=> $stable(pc_addr)); // R6

endmodule

bind jump_pc pcs_checker #(
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W),
    .HI_W   (HI_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_in  (bus_in),
    .hi_wr   (hi_wr),
    .pc_wr   (pc_wr),
    .pc_inc  (pc_inc),
    .pc_addr (pc_addr),
    .stage_q (stage_q)
);

// File: tb/sim_jump_pc.sv
`timescale 1ns/1ps
module sim_jump_pc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_in = '0;
    logic        hi_wr = 1'b0;
    logic        pc_wr = 1'b0;
    logic        pc_inc = 1'b0;
    logic [15:0] pc_addr;

    int ref_pc = 0;
    int ref_hi = 0;
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    jump_pc u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_in  (bus_in),
        .hi_wr   (hi_wr),
        .pc_wr   (pc_wr),
        .pc_inc  (pc_inc),
        .pc_addr (pc_addr)
    );

    task automatic check(input string tag);
        n_run++;
        if (pc_addr !== 16'(ref_pc)) begin
            n_fail++;
            $display("FAIL %s: pc_addr=%h expected %h", tag, pc_addr, 16'(ref_pc));
        end
    endtask

    // Called at a falling edge: drive, advance model at rising edge, compare at next falling edge.
    task automatic cyc(input bit h, input bit w, input bit i, input logic [7:0] b, input string tag);
        int old_hi;
        hi_wr = h; pc_wr = w; pc_inc = i; bus_in = b;
        @(posedge clk);
        old_hi = ref_hi;
        if (w)      ref_pc = (old_hi << 8) | int'(b);
        else if (i) ref_pc = (ref_pc + 1) % 65536;
        if (h)      ref_hi = int'(b);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");
        cyc(0, 1, 0, 8'h34, "R1 jump with cleared stage");
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 8'h00, "R2 step");
        cyc(1, 0, 0, 8'h12, "R6 stage write only");
        cyc(0, 1, 0, 8'h56, "R5 jump");
        cyc(0, 0, 1, 8'h00, "R7 step between jumps");
        cyc(0, 1, 0, 8'h78, "R7 second jump same page");
        cyc(1, 0, 0, 8'h00, "R6 stage write only");
        cyc(0, 1, 0, 8'hFE, "R5 jump");
        cyc(0, 0, 1, 8'h00, "R2 step");
        cyc(0, 0, 1, 8'h00, "R3 carry into high byte");
        cyc(1, 0, 0, 8'hFF, "R6 stage write only");
        cyc(0, 1, 0, 8'hFF, "R5 jump to top");
        cyc(0, 0, 1, 8'h00, "R4 wrap");
        cyc(0, 1, 1, 8'h10, "R8 write beats step");
        cyc(1, 1, 0, 8'h33, "R9 jump uses old stage");
        cyc(0, 1, 0, 8'h44, "R9 new stage used next");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 8'hA5, "R10 hold");
        for (int k = 0; k < 300; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            cyc(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 2) == 0, r,
                "R2 R5 R8 R9 random mix");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: pc_addr=%h expected %h", pc_addr, 16'(ref_pc));
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule